// File: doc/BRIEF.md
# Serial Receive Start Controller

This block decides when a synchronous serial receiver captures data and when it stops. It watches a frame-sync line, a pulse from the transmit side that marks a transmit start, two single-cycle compare-match pulses and an end-of-word pulse from the data shifter. From these inputs it drives four outputs:

- a receive-active level;
- a gated clock-enable for the shifter;
- a one-cycle start strobe at every start of reception;
- a free-running frame-sync period pulse.

The shifter, word assembly and compare-pattern matching sit outside the block.

A 4-bit start selector picks the trigger. The choices are:

- free-running;
- transmit start;
- frame-sync low or high level;
- frame-sync falling or rising edge;
- any change of frame-sync (codes 6 and 7 behave the same);
- a compare-0 match.

A stop-mode bit chooses how compare-0 reception ends. When clear, reception ends after one word. When set, reception continues until a compare-1 match. A programmable delay can hold off the real start by a number of clocks. A 2-bit gating field limits the shifter clock-enable to phases of frame-sync. A period field makes a pulse every 2×(period+1) clocks.

Top module: `rx_start_ctrl`

## Requirements
- R1: After reset, and before any enable, `rxActive`, `startStrobe`, `rxClkEn` and `periodPulse` are all 0.
- R2: With select code 0 and no delay, reception starts at the first clock edge at which `rxEnable` is high. While active in code 0, an `xferDone` pulse restarts reception through the start delay, with a fresh `startStrobe`.
- R3: With select code 1, a `txStart` pulse starts reception.
- R4: Codes 2 and 3 start reception while the synchronized frame-sync is low (code 2) or high (code 3). `fsIn` passes through two synchronizing flops, so a level change at the pin reaches the trigger 3 edges later.
- R5: Code 4 starts on a falling edge and code 5 on a rising edge of the synchronized frame-sync. Edges are found by comparing each sample with the one before it. A change of the other polarity does not start reception.
- R6: Codes 6 and 7 start on any change of the synchronized frame-sync, and never on a steady level.
- R7: Code 8 starts on a `cmp0Hit` pulse. With `cfgStopCont`=0, the next `xferDone` ends reception, and it stays idle until another `cmp0Hit`.
- R8: With code 8 and `cfgStopCont`=1, `xferDone` does not end reception and gives no strobe. A `cmp1Hit` pulse ends it at the next edge.
- R9: Select codes 9 to 15 never start reception.
- R10: A start delay of N≥1 makes `rxActive` rise N edges after the edge that accepted the start event. A start event that arrives while the delay runs is ignored. The delay also applies to code 1.
- R11: With `cfgPeriod`=0, `periodPulse` never fires. With P>0, it is high for one cycle after every 2×(P+1)-th edge counted from the enabling edge.
- R12: `rxClkEn` is `rxActive` ANDed with a gate term on the synchronized frame-sync. The gate term is 1 for codes 0 and 3, frame-sync low for code 1, and frame-sync high for code 2.
- R13: Deasserting `rxEnable` makes `rxActive` low after the next edge and clears the delay and period counters. The period count restarts from zero on re-enable.
- R14: `startStrobe` is high for exactly the one cycle in which `rxActive` is entered or a code-0 restart occurs, and only while `rxActive` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rxEnable | input | 1 | Receiver enable; low forces idle |
| fsIn | input | 1 | Frame-sync pin, asynchronous |
| txStart | input | 1 | Transmit-start pulse |
| cmp0Hit | input | 1 | Compare-0 match pulse |
| cmp1Hit | input | 1 | Compare-1 match pulse |
| xferDone | input | 1 | End-of-word pulse from the shifter |
| cfgStartSel | input | 4 | Start trigger select (0..8, 9..15 reserved) |
| cfgStopCont | input | 1 | Compare-0 stop mode: 0 one word, 1 until compare-1 |
| cfgGate | input | 2 | Shifter clock-enable gating mode |
| cfgDelay | input | DLY_W | Start delay in clocks |
| cfgPeriod | input | PER_W | Period divider; 0 disables |
| rxActive | output | 1 | Reception in progress |
| rxClkEn | output | 1 | Gated shifter clock-enable |
| periodPulse | output | 1 | Frame-sync period pulse |
| startStrobe | output | 1 | One-cycle start-of-reception strobe |

## Verification
Pulse triggers (`txStart`, `cmp0Hit`, `xferDone`, `cmp1Hit`) driven before edge k change `rxActive` right after edge k, or after edge k+N with a delay of N. Frame-sync changes appear 3 edges later, and `rxClkEn` follows frame-sync after 2 edges. The period pulse is due after edge 2×(P+1)·m counted from the enabling edge. The bench drives every input at a falling clock edge and samples after each following rising edge. It compares the value against an edge index computed for that trigger code, pin history and delay. Each sample is therefore checked at the exact edge on which it must change, and also on the edges just before that.

// File: rtl/rx_start_pkg.sv
package rx_start_pkg;

  localparam logic [3:0] START_FREE      = 4'd0;
  localparam logic [3:0] START_TX        = 4'd1;
  localparam logic [3:0] START_FS_LOW    = 4'd2;
  localparam logic [3:0] START_FS_HIGH   = 4'd3;
  localparam logic [3:0] START_FS_FALL   = 4'd4;
  localparam logic [3:0] START_FS_RISE   = 4'd5;
  localparam logic [3:0] START_FS_CHANGE = 4'd6;
  localparam logic [3:0] START_FS_EDGE   = 4'd7;
  localparam logic [3:0] START_CMP0      = 4'd8;

  localparam logic [1:0] GATE_FS_LOW  = 2'd1;
  localparam logic [1:0] GATE_FS_HIGH = 2'd2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DELAY = 2'd1,
    ST_RUN   = 2'd2
  } rxState_e;

  // control -> datapath
  typedef struct packed {
    logic loadDelay;
    logic clearAll;
  } ctlStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic trigger;
    logic delayZero;
    logic delayDone;
  } dpStatus_t;

endpackage

// File: rtl/rx_start_dp.sv
module rx_start_dp
  import rx_start_pkg::*;
#(
  parameter int DLY_W       = 8,
  parameter int PER_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fsIn,
  input  logic             txStart,
  input  logic             cmp0Hit,
  input  logic [3:0]       cfgStartSel,
  input  logic [1:0]       cfgGate,
  input  logic [DLY_W-1:0] cfgDelay,
  input  logic [PER_W-1:0] cfgPeriod,
  input  ctlStrobe_t       ctl,
  output dpStatus_t        status,
  output logic             gateOk,
  output logic             periodPulse
);

  localparam int PCNT_W = PER_W + 1;

  logic [SYNC_STAGES-1:0] fsSync;
  logic                   fsNow;
  logic                   fsPrev;
  logic                   fsRise;
  logic                   fsFall;
  logic [DLY_W-1:0]       dlyCnt;
  logic [PCNT_W-1:0]      perCnt;
  logic [PCNT_W-1:0]      perLast;
  logic                   trig;

  // frame-sync synchronizer plus one history flop
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fsSync <= '0;
      fsPrev <= 1'b0;
    end else begin
      fsSync <= {fsSync[SYNC_STAGES-2:0], fsIn};
      fsPrev <= fsSync[SYNC_STAGES-1];
    end
  end

  assign fsNow  = fsSync[SYNC_STAGES-1];
  assign fsRise = fsNow & ~fsPrev;
  assign fsFall = ~fsNow & fsPrev;

  always_comb begin
    case (cfgStartSel)
      START_FREE:      trig = 1'b1;
      START_TX:        trig = txStart;
      START_FS_LOW:    trig = ~fsNow;
      START_FS_HIGH:   trig = fsNow;
      START_FS_FALL:   trig = fsFall;
      START_FS_RISE:   trig = fsRise;
      START_FS_CHANGE,
      START_FS_EDGE:   trig = fsRise | fsFall;
      START_CMP0:      trig = cmp0Hit;
      default:         trig = 1'b0;
    endcase
  end

  // start delay down-counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              dlyCnt <= '0;
    else if (ctl.clearAll)  dlyCnt <= '0;
    else if (ctl.loadDelay) dlyCnt <= cfgDelay;
    else if (dlyCnt != '0)  dlyCnt <= dlyCnt - 1'b1;
  end

  // period generator: 2*(P+1) clocks per pulse
  assign perLast = {cfgPeriod, 1'b1};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      perCnt      <= '0;
      periodPulse <= 1'b0;
    end else if (ctl.clearAll || cfgPeriod == '0) begin
      perCnt      <= '0;
      periodPulse <= 1'b0;
    end else if (perCnt == perLast) begin
      perCnt      <= '0;
      periodPulse <= 1'b1;
    end else begin
      perCnt      <= perCnt + 1'b1;
      periodPulse <= 1'b0;
    end
  end

  always_comb begin
    case (cfgGate)
      GATE_FS_LOW:  gateOk = ~fsNow;
      GATE_FS_HIGH: gateOk = fsNow;
      default:      gateOk = 1'b1;
    endcase
  end

  assign status.trigger   = trig;
  assign status.delayZero = (cfgDelay == '0);
  assign status.delayDone = (dlyCnt == DLY_W'(1));

endmodule

// File: rtl/rx_start_fsm.sv
module rx_start_fsm
  import rx_start_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxEnable,
  input  logic       xferDone,
  input  logic       cmp1Hit,
  input  logic [3:0] cfgStartSel,
  input  logic       cfgStopCont,
  input  dpStatus_t  status,
  output ctlStrobe_t ctl,
  output logic       rxActive,
  output logic       startStrobe
);

  rxState_e state;
  rxState_e stateNxt;
  logic     strobeNxt;
  logic     beginStart;

  always_comb begin
    stateNxt      = state;
    strobeNxt     = 1'b0;
    beginStart    = 1'b0;
    ctl.loadDelay = 1'b0;
    ctl.clearAll  = ~rxEnable;
    if (!rxEnable) begin
      stateNxt = ST_IDLE;
    end else begin
      case (state)
        ST_IDLE:  beginStart = status.trigger;
        ST_DELAY: if (status.delayDone) begin
                    stateNxt  = ST_RUN;
                    strobeNxt = 1'b1;
                  end
        ST_RUN: begin
          if (cfgStartSel == START_CMP0 && cfgStopCont) begin
            if (cmp1Hit) stateNxt = ST_IDLE;
          end else if (xferDone) begin
            if (cfgStartSel == START_FREE) beginStart = 1'b1;
            else                           stateNxt   = ST_IDLE;
          end
        end
        default:  stateNxt = ST_IDLE;
      endcase
      if (beginStart) begin
        if (status.delayZero) begin
          stateNxt  = ST_RUN;
          strobeNxt = 1'b1;
        end else begin
          stateNxt      = ST_DELAY;
          ctl.loadDelay = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      startStrobe <= 1'b0;
    end else begin
      state       <= stateNxt;
      startStrobe <= strobeNxt;
    end
  end

  assign rxActive = (state == ST_RUN);

endmodule

// File: rtl/rx_start_ctrl.sv
module rx_start_ctrl
  import rx_start_pkg::*;
#(
  parameter int DLY_W       = 8,
  parameter int PER_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxEnable,
  input  logic             fsIn,
  input  logic             txStart,
  input  logic             cmp0Hit,
  input  logic             cmp1Hit,
  input  logic             xferDone,
  input  logic [3:0]       cfgStartSel,
  input  logic             cfgStopCont,
  input  logic [1:0]       cfgGate,
  input  logic [DLY_W-1:0] cfgDelay,
  input  logic [PER_W-1:0] cfgPeriod,
  output logic             rxActive,
  output logic             rxClkEn,
  output logic             periodPulse,
  output logic             startStrobe
);

  ctlStrobe_t ctl;
  dpStatus_t  status;
  logic       gateOk;

  rx_start_dp #(
    .DLY_W(DLY_W), .PER_W(PER_W), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .fsIn(fsIn), .txStart(txStart),
    .cmp0Hit(cmp0Hit), .cfgStartSel(cfgStartSel), .cfgGate(cfgGate),
    .cfgDelay(cfgDelay), .cfgPeriod(cfgPeriod), .ctl(ctl),
    .status(status), .gateOk(gateOk), .periodPulse(periodPulse)
  );

  rx_start_fsm u_fsm (
    .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .xferDone(xferDone),
    .cmp1Hit(cmp1Hit), .cfgStartSel(cfgStartSel),
    .cfgStopCont(cfgStopCont), .status(status), .ctl(ctl),
    .rxActive(rxActive), .startStrobe(startStrobe)
  );

  assign rxClkEn = rxActive & gateOk;

endmodule

// File: rtl/rx_start_chk.sv
module rx_start_chk (
  input logic       clk,
  input logic       rstN,
  input logic       rxEnable,
  input logic       cmp1Hit,
  input logic       xferDone,
  input logic [3:0] cfgStartSel,
  input logic       cfgStopCont,
  input logic       rxActive,
  input logic       rxClkEn,
  input logic       periodPulse,
  input logic       startStrobe
);

  p_disable_idle_r13: assert property (@(posedge clk) disable iff (!rstN)
    !rxEnable |=> !rxActive);

  p_period_off_r13: assert property (@(posedge clk) disable iff (!rstN)
    !rxEnable |=> !periodPulse);

  p_strobe_on_rise_r14: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxActive) |-> startStrobe);

  p_strobe_active_r14: assert property (@(posedge clk) disable iff (!rstN)
    startStrobe |-> rxActive);

  p_gate_active_r12: assert property (@(posedge clk) disable iff (!rstN)
    rxClkEn |-> rxActive);

  p_oneshot_stop_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rxActive && xferDone && cfgStartSel == 4'd8 && !cfgStopCont) |=> !rxActive);

  p_cmp1_stop_r8: assert property (@(posedge clk) disable iff (!rstN)
    (rxActive && cmp1Hit && cfgStartSel == 4'd8 && cfgStopCont) |=> !rxActive);

  p_cont_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (rxActive && rxEnable && !cmp1Hit && cfgStartSel == 4'd8 && cfgStopCont)
      |=> rxActive);

endmodule

bind rx_start_ctrl rx_start_chk u_chk (
  .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .cmp1Hit(cmp1Hit),
  .xferDone(xferDone), .cfgStartSel(cfgStartSel), .cfgStopCont(cfgStopCont),
  .rxActive(rxActive), .rxClkEn(rxClkEn), .periodPulse(periodPulse),
  .startStrobe(startStrobe)
);

// File: tb/test_rx_start_ctrl.sv
`timescale 1ns/1ps
module test_rx_start_ctrl;

  localparam int DLY_W = 8;
  localparam int PER_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxEnable = 1'b0, fsIn = 1'b0, txStart = 1'b0;
  logic cmp0Hit = 1'b0, cmp1Hit = 1'b0, xferDone = 1'b0;
  logic [3:0] cfgStartSel = 4'd9;
  logic cfgStopCont = 1'b0;
  logic [1:0] cfgGate = 2'd0;
  logic [DLY_W-1:0] cfgDelay = '0;
  logic [PER_W-1:0] cfgPeriod = '0;
  logic rxActive, rxClkEn, periodPulse, startStrobe;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  rx_start_ctrl #(.DLY_W(DLY_W), .PER_W(PER_W)) i_rx_start_ctrl (
    .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .fsIn(fsIn),
    .txStart(txStart), .cmp0Hit(cmp0Hit), .cmp1Hit(cmp1Hit),
    .xferDone(xferDone), .cfgStartSel(cfgStartSel),
    .cfgStopCont(cfgStopCont), .cfgGate(cfgGate), .cfgDelay(cfgDelay),
    .cfgPeriod(cfgPeriod), .rxActive(rxActive), .rxClkEn(rxClkEn),
    .periodPulse(periodPulse), .startStrobe(startStrobe)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chkEq(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic string reqFor(input int sel);
    case (sel)
      0: return "R2";
      1: return "R3";
      2, 3: return "R4";
      4, 5: return "R5";
      6, 7: return "R6";
      8: return "R7";
      default: return "R9";
    endcase
  endfunction

  // edge index (after enable) at which rxActive rises; 0 = never
  function automatic int riseEdge(input int sel, input int a, input int b);
    case (sel)
      0: return 1;
      2: return (a == 0) ? 1 : ((b == 0) ? 3 : 0);
      3: return (a == 1) ? 1 : ((b == 1) ? 3 : 0);
      4: return (a == 1 && b == 0) ? 3 : 0;
      5: return (a == 0 && b == 1) ? 3 : 0;
      6, 7: return (a != b) ? 3 : 0;
      default: return 0;
    endcase
  endfunction

  task automatic restartEnable();
    rxEnable = 1'b0;
    tick();
    rxEnable = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    chkEq("R1 rxActive in reset", rxActive, 0);
    rstN = 1'b1;
    repeat (2) tick();
    chkEq("R1 rxActive", rxActive, 0);
    chkEq("R1 startStrobe", startStrobe, 0);
    chkEq("R1 rxClkEn", rxClkEn, 0);
    chkEq("R1 periodPulse", periodPulse, 0);

    // sweep all select codes against every frame-sync transition
    for (int sel = 0; sel < 16; sel++) begin
      for (int a = 0; a < 2; a++) begin
        for (int b = 0; b < 2; b++) begin
          int rise;
          rxEnable = 1'b0;
          fsIn = a[0];
          cfgStartSel = sel[3:0];
          repeat (4) tick();
          rxEnable = 1'b1;
          fsIn = b[0];
          rise = riseEdge(sel, a, b);
          for (int j = 1; j <= 6; j++) begin
            tick();
            chkEq($sformatf("%s sel=%0d fs %0d->%0d edge %0d active", reqFor(sel), sel, a, b, j),
                  rxActive, (rise != 0 && j >= rise) ? 1 : 0);
            chkEq($sformatf("R14 sel=%0d fs %0d->%0d edge %0d strobe", sel, a, b, j),
                  startStrobe, (j == rise) ? 1 : 0);
          end
        end
      end
    end

    // start delay with transmit-start, second start during delay ignored (R10, R3)
    cfgStartSel = 4'd1;
    fsIn = 1'b0;
    for (int n = 0; n <= 5; n++) begin
      cfgDelay = n[DLY_W-1:0];
      restartEnable();
      repeat (2) tick();
      chkEq($sformatf("R3 idle before txStart n=%0d", n), rxActive, 0);
      txStart = 1'b1;
      for (int j = 1; j <= n + 3; j++) begin
        tick();
        txStart = (j == 1 && n >= 2);
        chkEq($sformatf("R10 delay=%0d edge %0d active", n, j), rxActive, (j >= n + 1) ? 1 : 0);
        chkEq($sformatf("R14 delay=%0d edge %0d strobe", n, j), startStrobe, (j == n + 1) ? 1 : 0);
      end
      txStart = 1'b0;
    end

    // code 0 restart after each word, with and without delay (R2)
    cfgStartSel = 4'd0;
    for (int d = 0; d <= 2; d += 2) begin
      cfgDelay = d[DLY_W-1:0];
      restartEnable();
      repeat (8) tick();
      chkEq($sformatf("R2 running delay=%0d", d), rxActive, 1);
      xferDone = 1'b1;
      for (int j = 1; j <= d + 2; j++) begin
        tick();
        xferDone = 1'b0;
        chkEq($sformatf("R2 restart delay=%0d edge %0d active", d, j), rxActive, (j >= d + 1) ? 1 : 0);
        chkEq($sformatf("R2 restart delay=%0d edge %0d strobe", d, j), startStrobe, (j == d + 1) ? 1 : 0);
      end
    end
    cfgDelay = '0;

    // compare-0 one-shot (R7)
    cfgStartSel = 4'd8;
    cfgStopCont = 1'b0;
    restartEnable();
    repeat (3) tick();
    chkEq("R7 idle before cmp0", rxActive, 0);
    cmp0Hit = 1'b1; tick(); cmp0Hit = 1'b0;
    chkEq("R7 active after cmp0", rxActive, 1);
    chkEq("R7 strobe after cmp0", startStrobe, 1);
    repeat (2) tick();
    chkEq("R7 still active", rxActive, 1);
    xferDone = 1'b1; tick(); xferDone = 1'b0;
    chkEq("R7 stop after word", rxActive, 0);
    repeat (3) tick();
    chkEq("R7 waits for cmp0", rxActive, 0);
    cmp0Hit = 1'b1; tick(); cmp0Hit = 1'b0;
    chkEq("R7 second cmp0 starts", rxActive, 1);

    // compare-0 continuous until compare-1 (R8)
    cfgStopCont = 1'b1;
    restartEnable();
    tick();
    cmp0Hit = 1'b1; tick(); cmp0Hit = 1'b0;
    chkEq("R8 active after cmp0", rxActive, 1);
    for (int k = 0; k < 2; k++) begin
      xferDone = 1'b1; tick(); xferDone = 1'b0;
      chkEq($sformatf("R8 word %0d keeps active", k), rxActive, 1);
      chkEq($sformatf("R8 word %0d no strobe", k), startStrobe, 0);
    end
    cmp1Hit = 1'b1; tick(); cmp1Hit = 1'b0;
    chkEq("R8 cmp1 stops", rxActive, 0);
    repeat (2) tick();
    chkEq("R8 stays idle", rxActive, 0);
    cfgStopCont = 1'b0;

    // period generator sweep (R11)
    cfgStartSel = 4'd9;
    for (int p = 0; p <= 5; p++) begin
      cfgPeriod = p[PER_W-1:0];
      restartEnable();
      for (int j = 1; j <= 30; j++) begin
        tick();
        chkEq($sformatf("R11 period=%0d edge %0d", p, j), periodPulse,
              (p != 0 && (j % (2 * (p + 1))) == 0) ? 1 : 0);
      end
    end

    // disable clears the period count (R13)
    cfgPeriod = 1;
    restartEnable();
    repeat (3) tick();
    rxEnable = 1'b0; tick();
    chkEq("R13 period pulse off while disabled", periodPulse, 0);
    rxEnable = 1'b1;
    for (int j = 1; j <= 4; j++) begin
      tick();
      chkEq($sformatf("R13 period restart edge %0d", j), periodPulse, (j == 4) ? 1 : 0);
    end
    cfgPeriod = '0;

    // clock gating (R12)
    cfgStartSel = 4'd0;
    restartEnable();
    repeat (2) tick();
    for (int g = 0; g < 4; g++) begin
      for (int f = 0; f < 2; f++) begin
        cfgGate = g[1:0];
        fsIn = f[0];
        repeat (3) tick();
        chkEq($sformatf("R12 gate=%0d fs=%0d", g, f), rxClkEn,
              (g == 1) ? (f == 0) : ((g == 2) ? (f == 1) : 1));
      end
    end
    cfgGate = 2'd0;
    rxEnable = 1'b0; tick();
    chkEq("R13 active drops in one clock", rxActive, 0);
    chkEq("R12 clock enable off when idle", rxClkEn, 0);

    // disable during a running delay (R13)
    cfgStartSel = 4'd1;
    cfgDelay = 4;
    rxEnable = 1'b1;
    repeat (2) tick();
    txStart = 1'b1; tick(); txStart = 1'b0;
    tick();
    rxEnable = 1'b0; tick();
    chkEq("R13 idle after disable in delay", rxActive, 0);
    rxEnable = 1'b1;
    for (int j = 1; j <= 8; j++) begin
      tick();
      chkEq($sformatf("R13 no stale start edge %0d", j), rxActive, 0);
    end

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule